// File: doc/BRIEF.md
# Chip-Select Bus Cycle Terminator

This block decides when an external bus cycle is over for a small memory controller that has several chip selects. Each chip select has an 8-bit option word that holds a 5-bit wait-state count and a 3-bit memory-type code. A single request strobe starts a cycle and carries the chip-select index and the transfer direction. The block then ends the cycle in one of three ways:

- by counting wait states,
- by waiting for an external active-low acknowledge, which has to arrive as a fresh falling edge,
- by waiting for a completion pulse from an SDRAM sequencer.

When the cycle ends, the block raises a one-clock `done` pulse.

While a cycle runs, the block drives one active-low chip-select line. It also drives the active-low read/write strobe, whose level depends on the memory type. The chip-select index and the option word are captured at the start of the cycle. They are held until the cycle ends, so changes to the inputs during a cycle have no effect.

Top module: `cs_cycle_end`

## Requirements
- R1: Option word i sits at `opt_cfg[8*i+7:8*i]`. The wait count is bits [4:0] and the memory type is bits [7:5]. The memory type codes are 0 and 1 for asynchronous SRAM/ROM, 2 for SDRAM, 3 for on-chip peripheral and 4 to 7 for on-chip RAM. For a non-SDRAM type with a wait count W from 0 to 30, a request accepted at clock edge E keeps `busy` high and raises `done` right after edge E+W+1.
- R2: `done` is high for exactly one clock per cycle. `busy` is low whenever `done` is high.
- R3: A wait count of 31 on a non-SDRAM type holds the cycle until `ta_n` falls. `ta_n` passes through a two-flop synchronizer, so `done` rises after the third rising edge after the fall. While `ta_n` stays high, the cycle never ends.
- R4: An acknowledge is taken only on a high-to-low transition after `ta_n` has been seen high. A `ta_n` that stays low from one cycle into the next does not end the new cycle.
- R5: For memory type 2 (SDRAM), the cycle ends on the first rising edge that samples `sdram_done` high. Both the wait count and `ta_n` are ignored.
- R6: For memory types 0 and 1, during the cycle `rw_n` is low for a write and high for a read.
- R7: `rw_n` is low during on-chip peripheral cycles (type 3) and high during on-chip RAM cycles (types 4 to 7) and SDRAM cycles. `rw_n` is high while idle.
- R8: A request is accepted only while idle. During a cycle, changes to `req_valid`, `req_cs`, `req_write` and `opt_cfg` do not alter the cycle length or the strobes, and they leave no request queued.
- R9: During a cycle, exactly `cs_n[index]` is low. While idle, all `cs_n` bits are high.
- R10: Synchronous reset returns the block to idle with `done` low and all strobes high. It also clears the acknowledge arming, so `ta_n` must be seen high again before a fall is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a cycle (accepted while idle) |
| req_cs | input | CS_W | Chip-select index of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| opt_cfg | input | 8*NUM_CS | Per-chip-select option words |
| ta_n | input | 1 | External active-low acknowledge (idles high) |
| sdram_done | input | 1 | Completion pulse from the SDRAM sequencer |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rw_n | output | 1 | Active-low read/write strobe |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions assume the following about the inputs:
- `sdram_done` is driven only by a sequencer that finishes in finite time.
- `ta_n` is a clean level, so that one fall is one acknowledge.
- Requests name an existing chip select.

The stimulus changes every input on the falling clock edge. It pulses `sdram_done` for one clock, and it moves `ta_n` only after the synchronizer has settled. It targets only indices 0 to 3 and uses an SDRAM wait count other than 31 solely to show that the count is ignored.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;

    localparam int WS_W   = 5;
    localparam int MODE_W = 3;
    localparam int OPT_W  = WS_W + MODE_W;
    localparam logic [WS_W-1:0] WS_ACK = '1;

    typedef enum logic [MODE_W-1:0] {
        MEM_ASYNC0 = 3'd0,
        MEM_ASYNC1 = 3'd1,
        MEM_SDRAM  = 3'd2,
        MEM_PERIPH = 3'd3,
        MEM_LOCAL  = 3'd4
    } mem_mode_e;

    typedef struct packed {
        mem_mode_e         mode;
        logic [WS_W-1:0]   ws;
    } cs_opt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ACK,
        ST_SDRAM
    } cyc_state_e;

    // Active-low strobe level for a given memory type and direction
    function automatic logic rw_level(input mem_mode_e m, input logic wr);
        case (m)
            MEM_ASYNC0, MEM_ASYNC1: return ~wr;
            MEM_PERIPH:             return 1'b0;
            default:                return 1'b1;
        endcase
    endfunction

    function automatic cyc_state_e entry_state(input cs_opt_t o);
        if (o.mode == MEM_SDRAM) return ST_SDRAM;
        if (o.ws == WS_ACK)      return ST_ACK;
        return ST_COUNT;
    endfunction

endpackage

// File: rtl/ta_edge.sv
module ta_edge (
    input  logic clk,
    input  logic rst,
    input  logic ta_n,
    output logic fall
);
    logic s1_q, s2_q, armed_q;

    // Two-flop synchronizer; reset value treats the line as not yet seen high
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            s1_q    <= ta_n;
            s2_q    <= s1_q;
            armed_q <= s2_q;
        end
    end

    assign fall = armed_q & ~s2_q;

    assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/ws_timer.sv
module ws_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit = run && (cnt_q == limit);

    assert_hit_bound_R1: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/cs_cycle_end.sv
module cs_cycle_end
    import cs_term_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_write,
    input  logic [OPT_W*NUM_CS-1:0] opt_cfg,
    input  logic                    ta_n,
    input  logic                    sdram_done,
    output logic                    busy,
    output logic                    done,
    output logic                    rw_n,
    output logic [NUM_CS-1:0]       cs_n
);
    localparam int SLOTS = 1 << CS_W;

    cs_opt_t          opts [SLOTS];
    cyc_state_e       state_q;
    logic [WS_W-1:0]  ws_q;
    logic             done_q, rw_q;
    logic [NUM_CS-1:0] csn_q;
    logic             accept, term, ws_hit, ta_fall;

    for (genvar i = 0; i < SLOTS; i++) begin : g_opt
        if (i < NUM_CS) begin : g_used
            assign opts[i] = cs_opt_t'(opt_cfg[i*OPT_W +: OPT_W]);
        end else begin : g_pad
            assign opts[i] = cs_opt_t'('0);
        end
    end

    ta_edge u_ta (
        .clk  (clk),
        .rst  (rst),
        .ta_n (ta_n),
        .fall (ta_fall)
    );

    ws_timer #(.W(WS_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (state_q == ST_COUNT),
        .limit (ws_q),
        .hit   (ws_hit)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        case (state_q)
            ST_COUNT: term = ws_hit;
            ST_ACK:   term = ta_fall;
            ST_SDRAM: term = sdram_done;
            default:  term = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ws_q    <= '0;
            done_q  <= 1'b0;
            rw_q    <= 1'b1;
            csn_q   <= '1;
        end else begin
            done_q <= term;
            if (accept) begin
                state_q <= entry_state(opts[req_cs]);
                ws_q    <= opts[req_cs].ws;
                rw_q    <= rw_level(opts[req_cs].mode, req_write);
                csn_q   <= ~(NUM_CS'(1) << req_cs);
            end else if (term) begin
                state_q <= ST_IDLE;
                rw_q    <= 1'b1;
                csn_q   <= '1;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign rw_n = rw_q;
    assign cs_n = csn_q;

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_idle_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&cs_n));
    assert_idle_rw_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> rw_n);
    assert_sdram_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SDRAM && !sdram_done) |=> busy);
    assert_hold_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !term) |=> (busy && $stable(cs_n) && $stable(rw_n)));

endmodule

// File: tb/cs_cycle_end_test.sv
module cs_cycle_end_test;
    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cs = '0;
    logic        req_write = 1'b0;
    logic [8*NCS-1:0] opt_cfg = '0;
    logic        ta_n = 1'b1;
    logic        sdram_done = 1'b0;
    logic        busy, done, rw_n;
    logic [NCS-1:0] cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cs_cycle_end #(.NUM_CS(NCS)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs),
        .req_write(req_write), .opt_cfg(opt_cfg), .ta_n(ta_n),
        .sdram_done(sdram_done), .busy(busy), .done(done), .rw_n(rw_n),
        .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int cs, input int mode, input int ws);
        opt_cfg[cs*8 +: 8] = {3'(mode), 5'(ws)};
    endtask

    // Drive a request; returns at the falling edge just after the accepting edge
    task automatic start(input int cs, input int wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_cs    = 2'(cs);
        req_write = wr[0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int maxn, output int j);
        j = 0;
        do begin
            @(negedge clk);
            j++;
        end while (!done && j < maxn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int j;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(rw_n == 1'b1, "R10 reset rw_n", rw_n, 1);
        chk(cs_n == 4'hF, "R10 reset cs_n", cs_n, 15);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1/R6/R9 sweep over every chip select and every counted wait value
        for (int cs = 0; cs < NCS; cs++) begin
            for (int ws = 0; ws < 31; ws++) begin
                int wr;
                wr = (cs + ws) % 2;
                set_cfg(cs, ws % 2, ws);
                start(cs, wr);
                chk(busy == 1'b1, "R1 busy", busy, 1);
                chk(cs_n == ~(4'b1 << cs), "R9 cs_n", cs_n, ~(4'b1 << cs) & 15);
                chk(rw_n == (wr ? 1'b0 : 1'b1), "R6 rw_n", rw_n, wr ? 0 : 1);
                wait_done(40, j);
                chk(j == ws + 1, "R1 length", j, ws + 1);
                chk(busy == 1'b0, "R2 busy at done", busy, 0);
                @(negedge clk);
                chk(done == 1'b0, "R2 pulse width", done, 0);
            end
        end

        // R7 strobe level for on-chip types
        set_cfg(0, 3, 2);
        start(0, 0);
        chk(rw_n == 1'b0, "R7 periph read", rw_n, 0);
        wait_done(40, j);
        start(0, 1);
        chk(rw_n == 1'b0, "R7 periph write", rw_n, 0);
        wait_done(40, j);
        set_cfg(0, 4, 2);
        start(0, 1);
        chk(rw_n == 1'b1, "R7 local ram write", rw_n, 1);
        wait_done(40, j);
        chk(j == 3, "R1 local ram length", j, 3);
        chk(rw_n == 1'b1, "R7 idle rw_n", rw_n, 1);

        // R8 inputs changed mid-cycle
        set_cfg(1, 0, 10);
        start(1, 1);
        req_valid = 1'b1;
        req_cs    = 2'd2;
        req_write = 1'b0;
        set_cfg(1, 4, 0);
        j = 0;
        do begin
            @(negedge clk);
            j++;
            if (j == 5) begin
                chk(cs_n == 4'b1101, "R8 cs_n held", cs_n, 13);
                chk(rw_n == 1'b0, "R8 rw_n held", rw_n, 0);
            end
            if (j == 10) req_valid = 1'b0;
        end while (!done && j < 40);
        chk(j == 11, "R8 length held", j, 11);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 nothing queued", busy, 0);

        // R3 acknowledge-terminated cycle
        set_cfg(0, 0, 31);
        start(0, 1);
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R3 waits while ta_n high", busy, 1);
        ta_n = 1'b0;
        wait_done(20, j);
        chk(j == 3, "R3 ack latency", j, 3);

        // R4 level held low into the next cycle
        start(0, 0);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R4 held level ignored", busy, 1);
        ta_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R4 rising edge no end", busy, 1);
        ta_n = 1'b0;
        wait_done(20, j);
        chk(j == 3, "R4 fresh fall ends", j, 3);
        ta_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 SDRAM ends only on sdram_done
        set_cfg(2, 2, 31);
        start(2, 1);
        chk(rw_n == 1'b1, "R7 sdram rw_n", rw_n, 1);
        ta_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R5 ta ignored", busy, 1);
        ta_n = 1'b1;
        repeat (3) @(negedge clk);
        sdram_done = 1'b1;
        @(negedge clk);
        sdram_done = 1'b0;
        chk(done == 1'b1, "R5 sdram_done ends", done, 1);
        set_cfg(3, 2, 3);
        start(3, 0);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R5 count ignored", busy, 1);
        sdram_done = 1'b1;
        @(negedge clk);
        sdram_done = 1'b0;
        chk(done == 1'b1, "R5 count ignored end", done, 1);
        repeat (4) @(negedge clk);

        // R10 reset mid-cycle, with ta_n low across reset
        set_cfg(3, 0, 20);
        start(3, 1);
        repeat (3) @(negedge clk);
        ta_n = 1'b0;
        rst  = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10 reset aborts", busy, 0);
        chk(cs_n == 4'hF, "R10 reset cs_n", cs_n, 15);
        chk(rw_n == 1'b1, "R10 reset rw_n", rw_n, 1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        start(0, 1);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R10 arming cleared", busy, 1);
        ta_n = 1'b1;
        repeat (4) @(negedge clk);
        ta_n = 1'b0;
        wait_done(20, j);
        chk(j == 3, "R10 ack after re-arm", j, 3);
        ta_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule